// File: doc/BRIEF.md
# Reuse-Filtering Cache Pair

This block keeps a small fully associative filter cache next to a two-way set-associative main cache. Each request is looked up in both structures in the same cycle. A line that misses in both is fetched through a simple fill interface. The returned line goes only into the filter, in the filter's least-recently-filled slot, and never into the main cache.

A later hit on a line that is still in the filter moves that line into the main cache. The line leaves the filter, and the least recently used line of the target main-cache set is dropped. As a result, the main cache holds only lines that were used at least twice. Lines that are used once age out of the filter and are discarded. The two structures never hold the same line.

Every response carries a two-bit source code: memory fill, main cache or filter. While a fill is outstanding, the block accepts no new request.

Top module: `reuse_filter_cache`

## Requirements
- R1: After reset both structures are empty, req_ready is 1, and resp_valid and fill_req are 0.
- R2: A request accepted while it misses in both structures raises fill_req in the next cycle, with fill_addr equal to the request address. fill_req and fill_addr then hold, and req_ready stays 0, until fill_valid is seen.
- R3: One cycle after fill_valid is accepted, resp_valid is 1, resp_src is 2'b00 and resp_data equals fill_data. The line is placed in the filter only, so the next access to it reports resp_src 2'b10.
- R4: A hit in the filter returns the filter's data with resp_src 2'b10 and moves the line into the main cache. The next access to that line reports resp_src 2'b01.
- R5: A hit in the main cache returns the stored data with resp_src 2'b01, and the line stays in the main cache.
- R6: The filter holds FILT lines. A new fill replaces the line filled longest ago. With FILT=4, after five fills that are never reused, the first of them misses again.
- R7: A promotion frees its filter slot, and the next fill uses that slot before any resident filter line is evicted.
- R8: Each main-cache set (index = address bits [$clog2(SETS)-1:0]) has two ways with LRU replacement. A promotion fills an empty way first; otherwise it replaces the way that was not used most recently. A hit refreshes its way.
- R9: A line evicted from the main cache is discarded, so the next access to it misses in both structures and requests a fill.
- R10: An accepted request that hits in either structure gives resp_valid exactly one cycle later, with no fill request.
- R11: No address hits in both structures at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Request can be accepted (no fill outstanding) |
| resp_valid | output | 1 | Response present, one-cycle pulse |
| resp_src | output | 2 | 00 memory fill, 01 main cache, 10 filter |
| resp_data | output | DATA_W | Line data of the response |
| fill_req | output | 1 | Fill outstanding |
| fill_addr | output | ADDR_W | Line address to fetch |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | DATA_W | Returned line |

## Verification
The bench uses the default parameters: a 12-bit line address, 16-bit lines, eight main sets and four filter entries. With a four-entry filter, the bench can reach filter eviction in five fills and show slot reuse after a promotion. Two ways per set let three lines that share index 0 force a main-cache victim, and a hit placed between promotions then decides which line is dropped. Every line's data comes from its address, so a wrong slot or a stale entry shows up as a data mismatch.

// File: rtl/reuse_filter_cache.sv
module reuse_filter_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int SETS   = 8,
  parameter int FILT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [1:0]        resp_src,
  output logic [DATA_W-1:0] resp_data,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int FI_W  = $clog2(FILT);
  localparam logic [FI_W-1:0] OLDEST = FI_W'(FILT - 1);

  logic              fv    [FILT];
  logic [ADDR_W-1:0] faddr [FILT];
  logic [DATA_W-1:0] fdata [FILT];
  logic [FI_W-1:0]   fage  [FILT];

  logic              mv    [SETS][2];
  logic [TAG_W-1:0]  mtag  [SETS][2];
  logic [DATA_W-1:0] mdata [SETS][2];
  logic              mlru  [SETS];

  logic              busy;
  logic [ADDR_W-1:0] miss_addr;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [FILT-1:0]   fh;
  logic [1:0]        mh;
  logic              hit_filt, hit_main, acc;
  logic [FI_W-1:0]   fidx, fvic;
  logic              mway;

  assign idx       = req_addr[IDX_W-1:0];
  assign tag       = req_addr[ADDR_W-1:IDX_W];
  assign req_ready = !busy;
  assign fill_req  = busy;
  assign fill_addr = miss_addr;
  assign acc       = req_valid && req_ready;

  for (genvar i = 0; i < FILT; i++) begin : g_fcmp
    assign fh[i] = fv[i] && (faddr[i] == req_addr);
  end
  for (genvar w = 0; w < 2; w++) begin : g_mcmp
    assign mh[w] = mv[idx][w] && (mtag[idx][w] == tag);
  end

  assign hit_filt = |fh;
  assign hit_main = |mh;
  assign mway = !mv[idx][0] ? 1'b0 : (!mv[idx][1] ? 1'b1 : mlru[idx]);

  always_comb begin
    fidx = '0;
    fvic = '0;
    for (int i = 0; i < FILT; i++) begin
      if (fh[i]) fidx = FI_W'(i);
      if (fage[i] == OLDEST) fvic = FI_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      miss_addr  <= '0;
      resp_valid <= 1'b0;
      resp_src   <= 2'b00;
      resp_data  <= '0;
      for (int i = 0; i < FILT; i++) begin
        fv[i]    <= 1'b0;
        faddr[i] <= '0;
        fdata[i] <= '0;
        fage[i]  <= FI_W'(i);
      end
      for (int s = 0; s < SETS; s++) begin
        mlru[s] <= 1'b0;
        for (int w = 0; w < 2; w++) begin
          mv[s][w]    <= 1'b0;
          mtag[s][w]  <= '0;
          mdata[s][w] <= '0;
        end
      end
    end else begin
      resp_valid <= 1'b0;
      if (acc) begin
        if (hit_main) begin
          resp_valid <= 1'b1;
          resp_src   <= 2'b01;
          resp_data  <= mdata[idx][mh[1]];
          mlru[idx]  <= !mh[1];
        end else if (hit_filt) begin
          resp_valid <= 1'b1;
          resp_src   <= 2'b10;
          resp_data  <= fdata[fidx];
          fv[fidx]   <= 1'b0;
          for (int j = 0; j < FILT; j++)
            if (fage[j] > fage[fidx]) fage[j] <= fage[j] - 1'b1;
          fage[fidx] <= OLDEST;
          mv[idx][mway]    <= 1'b1;
          mtag[idx][mway]  <= tag;
          mdata[idx][mway] <= fdata[fidx];
          mlru[idx]        <= !mway;
        end else begin
          busy      <= 1'b1;
          miss_addr <= req_addr;
        end
      end
      if (busy && fill_valid) begin
        busy        <= 1'b0;
        resp_valid  <= 1'b1;
        resp_src    <= 2'b00;
        resp_data   <= fill_data;
        fv[fvic]    <= 1'b1;
        faddr[fvic] <= miss_addr;
        fdata[fvic] <= fill_data;
        for (int j = 0; j < FILT; j++)
          if (fage[j] < OLDEST) fage[j] <= fage[j] + 1'b1;
        fage[fvic] <= '0;
      end
    end
  end
endmodule

// File: rtl/reuse_filter_cache_chk.sv
module reuse_filter_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              hit_main,
  input logic              hit_filt,
  input logic              fill_req,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              resp_valid,
  input logic [1:0]        resp_src
);
  assert_no_double_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !(hit_main && hit_filt));

  assert_hit_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (hit_main || hit_filt)) |=> (resp_valid && !fill_req));

  assert_main_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit_main) |=> (resp_src == 2'b01));

  assert_filt_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit_main && hit_filt) |=> (resp_src == 2'b10));

  assert_miss_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit_main && !hit_filt) |=> (fill_req && !req_ready && !resp_valid));

  assert_fill_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

  assert_fill_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_valid) |=> (resp_valid && resp_src == 2'b00 && req_ready));
endmodule

bind reuse_filter_cache reuse_filter_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .hit_main(hit_main), .hit_filt(hit_filt), .fill_req(fill_req),
  .fill_valid(fill_valid), .fill_addr(fill_addr), .resp_valid(resp_valid),
  .resp_src(resp_src)
);

// File: tb/reuse_filter_cache_tb.sv
module reuse_filter_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] SRC_MEM = 2'b00, SRC_MAIN = 2'b01, SRC_FILT = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic        req_ready, resp_valid, fill_req;
  logic [1:0]  resp_src;
  logic [15:0] resp_data;
  logic [11:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_data = '0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reuse_filter_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_src(resp_src),
    .resp_data(resp_data), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [15:0] line_of(input logic [11:0] a);
    return {4'h9, a} ^ 16'h5A3C;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic [1:0] exp_src, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_src != SRC_MEM) begin
      chk(resp_valid == 1'b1, req, "resp_valid", int'(resp_valid), 1);
      chk(resp_src == exp_src, req, "resp_src", int'(resp_src), int'(exp_src));
      chk(resp_data == line_of(a), req, "resp_data", int'(resp_data), int'(line_of(a)));
      chk(fill_req == 1'b0, req, "fill_req", int'(fill_req), 0);
    end else begin
      chk(fill_req && !req_ready && !resp_valid, req, "miss state",
          int'({fill_req, req_ready, resp_valid}), 3'b100);
      chk(fill_addr == a, req, "fill_addr", int'(fill_addr), int'(a));
      @(negedge clk);
      chk(fill_req && !req_ready && fill_addr == a, req, "fill hold",
          int'({fill_req, req_ready}), 2'b10);
      fill_valid = 1'b1;
      fill_data  = line_of(a);
      @(negedge clk);
      fill_valid = 1'b0;
      chk(resp_valid && resp_src == SRC_MEM, req, "fill resp",
          int'({resp_valid, resp_src}), 3'b100);
      chk(resp_data == line_of(a), req, "fill data", int'(resp_data), int'(line_of(a)));
      chk(req_ready && !fill_req, req, "ready after fill",
          int'({req_ready, fill_req}), 2'b10);
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid", int'(resp_valid), 0);
    chk(fill_req == 1'b0, "R1", "fill_req", int'(fill_req), 0);
  endtask

  task automatic t_reuse_path();
    access(12'h101, SRC_MEM,  "R2");
    access(12'h101, SRC_FILT, "R3");
    access(12'h101, SRC_MAIN, "R4");
    access(12'h101, SRC_MAIN, "R5");
  endtask

  task automatic t_filter_lru();
    for (int k = 0; k < 5; k++) access(12'h202 + 12'(k), SRC_MEM, "R6");
    access(12'h202, SRC_MEM,  "R6");
    access(12'h206, SRC_FILT, "R6");
  endtask

  task automatic t_slot_reuse();
    access(12'h207, SRC_MEM,  "R7");
    access(12'h204, SRC_FILT, "R7");
    access(12'h205, SRC_FILT, "R7");
  endtask

  task automatic t_main_lru();
    access(12'h300, SRC_MEM,  "R8");
    access(12'h300, SRC_FILT, "R8");
    access(12'h308, SRC_MEM,  "R8");
    access(12'h308, SRC_FILT, "R8");
    access(12'h300, SRC_MAIN, "R8");
    access(12'h310, SRC_MEM,  "R8");
    access(12'h310, SRC_FILT, "R8");
    access(12'h300, SRC_MAIN, "R8");
    access(12'h310, SRC_MAIN, "R8");
    access(12'h308, SRC_MEM,  "R9");
    access(12'h308, SRC_FILT, "R9");
    access(12'h300, SRC_MEM,  "R9");
  endtask

  task automatic t_latency();
    access(12'h204, SRC_MAIN, "R10");
    access(12'h206, SRC_MAIN, "R11");
    access(12'h101, SRC_MAIN, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reuse_path();
    t_filter_lru();
    t_slot_reuse();
    t_main_lru();
    t_latency();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule